// File: doc/BRIEF.md
# Instruction Byte Buffer with Interrupt Opcode Injection

This block sits between program memory and the decode/execute units of an 8-bit accumulator core. Program bytes are captured into an opcode register and two operand registers. A first-byte marker from the fetch side restarts the operand sequence and raises a one-cycle new-instruction strobe, which consumers use to load their own opcode copies. Bytes read from external data memory are registered and presented on the second data bus. The first data bus carries the accumulator.

Interrupt entry needs no dedicated vectoring hardware. The block holds an interrupt request pending until the next instruction boundary. At that boundary it discards the fetched opcode and puts the indirect jump opcode (A plus pointer) in its place. While the entry lasts, it drives zero onto both data buses and steers the handler vector onto the pointer bus. The existing jump path then lands on the handler. The address of the displaced opcode is handed to the stack write port, so a later return resumes the interrupted program with nothing lost.

Top module: `instr_buf_irq`

## Requirements
- R1: After reset, instr_o, both operand outputs, state_o, stack_we_o, irq_o and new_instr_o are all zero.
- R2: A cycle with fetch_en_i and first_i high and no interrupt accepted loads prog_byte_i into instr_o at that clock edge. The same edge clears both operand outputs and raises new_instr_o for exactly one cycle.
- R3: After an opcode, the next fetched byte with first_i low goes to opnd0_o and the one after to opnd1_o. Later operand bytes, up to the next first byte, change neither output.
- R4: When xdata_valid_i is high, xdata_i is registered and appears on data1_o after the clock edge. It holds when xdata_valid_i is low. data0_o follows acc_i outside interrupt entry.
- R5: A request (irq_req_i with source irq_src_i) is held pending. It is accepted only on a first-byte fetch, including one in the same cycle as the request, and never while an entry is already active.
- R6: On acceptance, instr_o becomes 0x73 in place of the fetched byte and new_instr_o pulses. irq_o stays high until the next first-byte fetch, which loads a real opcode.
- R7: While irq_o is high, data0_o and data1_o are 0x00.
- R8: While irq_o is high, dptr_bus_o equals 3 + 8*source, for source codes 0 external 0, 1 timer 0, 2 external 1, 3 timer 1 and 4 serial. Otherwise dptr_bus_o follows dptr_i.
- R9: On acceptance, stack_we_o is high for exactly one cycle, and stack_data_o holds the pc_i of the displaced opcode.
- R10: Operand bytes fetched while irq_o is high are dropped, and both operand outputs stay zero.
- R11: A second request that arrives while one is pending is ignored, and the first source is kept.
- R12: state_o is {irq_o, phase, new_instr_o}, where phase is high once at least one operand byte has been captured since the last opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_en_i | input | 1 | Program byte present this cycle |
| first_i | input | 1 | Present byte is the first of an instruction |
| prog_byte_i | input | 8 | Program memory byte |
| pc_i | input | 16 | Address of the present program byte |
| xdata_valid_i | input | 1 | External data byte valid |
| xdata_i | input | 8 | External data memory byte |
| acc_i | input | 8 | Accumulator value |
| dptr_i | input | 16 | Data pointer contents |
| irq_req_i | input | 1 | Interrupt request from arbiter |
| irq_src_i | input | 3 | Requesting source code |
| instr_o | output | 8 | Opcode bus |
| opnd0_o | output | 8 | First operand byte |
| opnd1_o | output | 8 | Second operand byte |
| data0_o | output | 8 | Accumulator-side data bus |
| data1_o | output | 8 | External data bus |
| dptr_bus_o | output | 16 | Pointer bus or handler vector |
| new_instr_o | output | 1 | Opcode register just loaded |
| irq_o | output | 1 | Interrupt entry active |
| stack_we_o | output | 1 | Return address write strobe |
| stack_data_o | output | 16 | Return address |
| state_o | output | 3 | Monitor state |

## Verification
A lost pending flag shows up as a boundary that loads the real opcode where 0x73 was due, visible one edge after that fetch. A wrong source register shows up as a wrong dptr_bus_o value during the entry cycle. A stale operand index shows up on the operand outputs and the middle state bit one edge after the next program byte. A mistaken entry flag is exposed by non-zero data buses or surviving operands in the same cycle it is wrong.

// File: rtl/instr_buf_pkg.sv
package instr_buf_pkg;
  localparam int unsigned BW = 8;
  localparam int unsigned AW = 16;
  localparam int unsigned SRC_W = 3;
  localparam logic [BW-1:0] OP_JMP_A_PTR = 8'h73;

  function automatic logic [AW-1:0] vec_addr(input logic [SRC_W-1:0] src,
                                              input int unsigned base,
                                              input int unsigned stride);
    vec_addr = AW'(base) + AW'(stride) * AW'(src);
  endfunction
endpackage

// File: rtl/ibuf_irq_gate.sv
module ibuf_irq_gate
  import instr_buf_pkg::*;
#(
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             req_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             accept_o,
  output logic             active_o,
  output logic [AW-1:0]    vec_o,
  output logic             stack_we_o,
  output logic [AW-1:0]    stack_pc_o
);
  logic             pend_q;
  logic [SRC_W-1:0] src_q;
  logic             active_q;
  logic [AW-1:0]    vec_q;
  logic             we_q;
  logic [AW-1:0]    pc_q;
  logic [SRC_W-1:0] take_src;

  assign accept_o = boundary_i && !active_q && (pend_q || req_i);
  assign take_src = pend_q ? src_q : src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      src_q  <= '0;
    end else if (accept_o) begin
      // a fresh request arriving as the held one is consumed becomes pending
      pend_q <= pend_q && req_i;
      if (pend_q && req_i) src_q <= src_i;
    end else if (!pend_q && req_i) begin
      pend_q <= 1'b1;
      src_q  <= src_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      vec_q    <= '0;
      we_q     <= 1'b0;
      pc_q     <= '0;
    end else begin
      we_q <= accept_o;
      if (accept_o) begin
        active_q <= 1'b1;
        vec_q    <= vec_addr(take_src, VEC_BASE, VEC_STRIDE);
        pc_q     <= pc_i;
      end else if (boundary_i) begin
        active_q <= 1'b0;
      end
    end
  end

  assign active_o   = active_q;
  assign vec_o      = vec_q;
  assign stack_we_o = we_q;
  assign stack_pc_o = pc_q;

  AST_NO_REENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && boundary_i |=> !active_q) else $error("reentry"); // R5
  AST_PEND_KEEPS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !accept_o |=> pend_q && $stable(src_q)) else $error("pending lost"); // R11
endmodule

// File: rtl/ibuf_byte_lanes.sv
module ibuf_byte_lanes
  import instr_buf_pkg::*;
#(
  parameter int unsigned N_OPND = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fetch_en_i,
  input  logic                      first_i,
  input  logic [BW-1:0]             byte_i,
  input  logic                      inject_i,
  input  logic                      entry_i,
  output logic [BW-1:0]             instr_o,
  output logic [N_OPND-1:0][BW-1:0] opnd_o,
  output logic                      new_o,
  output logic                      phase_o
);
  localparam int unsigned IW = $clog2(N_OPND + 1);

  logic [BW-1:0] instr_q;
  logic          new_q;
  logic [IW-1:0] idx_q;
  logic          opcode_ld;
  logic          opnd_ld;

  assign opcode_ld = fetch_en_i && first_i;
  assign opnd_ld   = fetch_en_i && !first_i && !entry_i && (idx_q < IW'(N_OPND));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= '0;
      new_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      new_q <= opcode_ld;
      if (opcode_ld) begin
        instr_q <= inject_i ? OP_JMP_A_PTR : byte_i;
        idx_q   <= '0;
      end else if (opnd_ld) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    logic [BW-1:0] op_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              op_q <= '0;
      else if (opcode_ld)                       op_q <= '0;
      else if (opnd_ld && idx_q == IW'(g))      op_q <= byte_i;
    end
    assign opnd_o[g] = op_q;
  end

  assign instr_o = instr_q;
  assign new_o   = new_q;
  assign phase_o = (idx_q != '0);

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(N_OPND)) else $error("idx overflow"); // R3
  AST_NEW_FROM_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_ld |=> new_q && !phase_o) else $error("new strobe"); // R2
  AST_NEW_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_q && !opcode_ld |=> !new_q) else $error("new stuck"); // R2
endmodule

// File: rtl/ibuf_xdata_reg.sv
module ibuf_xdata_reg
  import instr_buf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [BW-1:0] data_i,
  output logic [BW-1:0] data_o
);
  logic [BW-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (valid_i) q <= data_i;
  end
  assign data_o = q;

  AST_XDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o)) else $error("xdata moved"); // R4
endmodule

// File: rtl/instr_buf_irq.sv
module instr_buf_irq
  import instr_buf_pkg::*;
#(
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_en_i,
  input  logic             first_i,
  input  logic [BW-1:0]    prog_byte_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             xdata_valid_i,
  input  logic [BW-1:0]    xdata_i,
  input  logic [BW-1:0]    acc_i,
  input  logic [AW-1:0]    dptr_i,
  input  logic             irq_req_i,
  input  logic [SRC_W-1:0] irq_src_i,
  output logic [BW-1:0]    instr_o,
  output logic [BW-1:0]    opnd0_o,
  output logic [BW-1:0]    opnd1_o,
  output logic [BW-1:0]    data0_o,
  output logic [BW-1:0]    data1_o,
  output logic [AW-1:0]    dptr_bus_o,
  output logic             new_instr_o,
  output logic             irq_o,
  output logic             stack_we_o,
  output logic [AW-1:0]    stack_data_o,
  output logic [2:0]       state_o
);
  localparam int unsigned N_OPND = 2;

  logic                      accept;
  logic                      active;
  logic [AW-1:0]             vec;
  logic [N_OPND-1:0][BW-1:0] opnd;
  logic                      phase;
  logic [BW-1:0]             xdata_q;

  ibuf_irq_gate #(.VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (fetch_en_i && first_i),
    .pc_i       (pc_i),
    .req_i      (irq_req_i),
    .src_i      (irq_src_i),
    .accept_o   (accept),
    .active_o   (active),
    .vec_o      (vec),
    .stack_we_o (stack_we_o),
    .stack_pc_o (stack_data_o)
  );

  ibuf_byte_lanes #(.N_OPND(N_OPND)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_en_i (fetch_en_i),
    .first_i    (first_i),
    .byte_i     (prog_byte_i),
    .inject_i   (accept),
    .entry_i    (active),
    .instr_o    (instr_o),
    .opnd_o     (opnd),
    .new_o      (new_instr_o),
    .phase_o    (phase)
  );

  ibuf_xdata_reg u_xdata (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (xdata_valid_i),
    .data_i  (xdata_i),
    .data_o  (xdata_q)
  );

  assign opnd0_o    = opnd[0];
  assign opnd1_o    = opnd[1];
  assign irq_o      = active;
  assign data0_o    = active ? '0 : acc_i;
  assign data1_o    = active ? '0 : xdata_q;
  assign dptr_bus_o = active ? vec : dptr_i;
  assign state_o    = {active, phase, new_instr_o};

  AST_INJECT_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> instr_o == OP_JMP_A_PTR) else $error("no inject"); // R6
  AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fetch_en_i && first_i)) else $error("mid entry"); // R5
  AST_OPND_CLEAR_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> opnd0_o == '0 && opnd1_o == '0) else $error("opnd leak"); // R10
  AST_STACK_WITH_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_we_o |-> irq_o && new_instr_o) else $error("stack strobe"); // R9
  AST_STACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_we_o |=> !stack_we_o) else $error("stack twice"); // R9
endmodule

// File: tb/instr_buf_irq_tb.sv
module instr_buf_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_en = 1'b0, first = 1'b0;
  logic [7:0]  prog_byte = '0;
  logic [15:0] pc = '0;
  logic        xvalid = 1'b0;
  logic [7:0]  xdata = '0, acc = '0;
  logic [15:0] dptr = '0;
  logic        req = 1'b0;
  logic [2:0]  src = '0;
  logic [7:0]  instr, opnd0, opnd1, data0, data1;
  logic [15:0] dptr_bus, stack_data;
  logic        new_instr, irq, stack_we;
  logic [2:0]  state;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_buf_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_en_i(fetch_en), .first_i(first),
    .prog_byte_i(prog_byte), .pc_i(pc), .xdata_valid_i(xvalid), .xdata_i(xdata),
    .acc_i(acc), .dptr_i(dptr), .irq_req_i(req), .irq_src_i(src),
    .instr_o(instr), .opnd0_o(opnd0), .opnd1_o(opnd1), .data0_o(data0),
    .data1_o(data1), .dptr_bus_o(dptr_bus), .new_instr_o(new_instr), .irq_o(irq),
    .stack_we_o(stack_we), .stack_data_o(stack_data), .state_o(state)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  // drive one cycle; inputs applied at negedge, sampled at the following negedge
  task automatic cyc(input logic fe, input logic fi, input logic [7:0] b, input logic [15:0] p,
                     input logic rq, input logic [2:0] s);
    fetch_en = fe; first = fi; prog_byte = b; pc = p; req = rq; src = s;
    @(posedge clk); @(negedge clk);
    fetch_en = 0; first = 0; req = 0;
  endtask

  task automatic t_reset();
    chk("R1 instr", instr, 0); chk("R1 opnd0", opnd0, 0); chk("R1 opnd1", opnd1, 0);
    chk("R1 state", state, 0); chk("R1 stack_we", stack_we, 0);
    chk("R1 irq", irq, 0); chk("R1 new", new_instr, 0);
  endtask

  task automatic t_normal();
    cyc(1, 1, 8'hE5, 16'h0100, 0, 0);
    chk("R2 instr", instr, 8'hE5); chk("R2 new", new_instr, 1);
    chk("R12 state opcode", state, 3'b001);
    cyc(1, 0, 8'h30, 16'h0101, 0, 0);
    chk("R2 new one cycle", new_instr, 0); chk("R3 opnd0", opnd0, 8'h30);
    chk("R12 state phase", state, 3'b010);
    cyc(1, 0, 8'h44, 16'h0102, 0, 0);
    chk("R3 opnd1", opnd1, 8'h44);
    cyc(1, 0, 8'h99, 16'h0103, 0, 0);
    chk("R3 extra opnd0", opnd0, 8'h30); chk("R3 extra opnd1", opnd1, 8'h44);
    cyc(0, 0, 8'h11, 16'h0104, 0, 0);
    chk("R3 idle opnd0", opnd0, 8'h30);
    cyc(1, 1, 8'h04, 16'h0104, 0, 0);
    chk("R2 opnd cleared", opnd0, 0); chk("R2 opnd1 cleared", opnd1, 0);
    chk("R2 instr2", instr, 8'h04);
  endtask

  task automatic t_xdata();
    acc = 8'hC3; dptr = 16'h1234;
    xvalid = 1; xdata = 8'h5A;
    cyc(0, 0, 0, 0, 0, 0);
    xvalid = 0; xdata = 8'hFF;
    chk("R4 data1", data1, 8'h5A); chk("R4 data0", data0, 8'hC3);
    chk("R8 dptr passthrough", dptr_bus, 16'h1234);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R4 hold", data1, 8'h5A);
  endtask

  task automatic t_irq_boundary();
    cyc(1, 1, 8'h75, 16'h0200, 0, 0);
    cyc(1, 0, 8'h20, 16'h0201, 1, 3'd1);
    chk("R5 no mid entry", irq, 0); chk("R5 opnd kept", opnd0, 8'h20);
    cyc(1, 0, 8'h21, 16'h0202, 1, 3'd3);
    chk("R5 still none", irq, 0);
    cyc(1, 1, 8'hE4, 16'h0203, 0, 0);
    chk("R6 inject", instr, 8'h73); chk("R6 new", new_instr, 1); chk("R6 irq", irq, 1);
    chk("R7 data0 zero", data0, 0); chk("R7 data1 zero", data1, 0);
    chk("R11 first src vector", dptr_bus, 16'h000B);
    chk("R9 stack we", stack_we, 1); chk("R9 stack pc", stack_data, 16'h0203);
    chk("R12 state entry", state, 3'b101);
    cyc(1, 0, 8'h66, 16'h0204, 0, 0);
    chk("R10 opnd0 dropped", opnd0, 0); chk("R10 opnd1", opnd1, 0);
    chk("R9 single", stack_we, 0); chk("R6 irq held", irq, 1);
    chk("R12 no phase", state, 3'b100);
    cyc(1, 1, 8'hC3, 16'h000B, 0, 0);
    chk("R6 exit irq", irq, 0); chk("R6 real opcode", instr, 8'hC3);
    chk("R8 dptr back", dptr_bus, 16'h1234); chk("R7 data0 back", data0, 8'hC3);
  endtask

  task automatic t_vectors();
    for (int s = 0; s < 5; s++) begin
      cyc(1, 1, 8'h00, 16'h0300 + 16'(s), 1, 3'(s));
      chk("R8 vector", dptr_bus, 16'(3 + 8 * s));
      chk("R5 same cycle", irq, 1);
      chk("R9 stack pc", stack_data, 16'h0300 + 16'(s));
      cyc(1, 1, 8'h00, 16'(3 + 8 * s), 0, 0);
      chk("R6 exit", irq, 0);
    end
  endtask

  task automatic t_req_during_entry();
    cyc(1, 1, 8'h10, 16'h0400, 1, 3'd2);
    chk("R5 entry", irq, 1);
    cyc(0, 0, 0, 0, 1, 3'd4);
    cyc(1, 1, 8'h12, 16'h0013, 0, 0);
    chk("R5 not while active", irq, 0); chk("R5 real", instr, 8'h12);
    cyc(1, 1, 8'h14, 16'h0014, 0, 0);
    chk("R5 later taken", irq, 1); chk("R8 serial vec", dptr_bus, 16'h0023);
    cyc(1, 1, 8'h00, 16'h0023, 0, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_xdata();
    t_irq_boundary();
    t_vectors();
    t_req_during_entry();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule